// File: doc/BRIEF.md
# Windowed Button Press Detector

This block watches one mechanical push-button and turns on an LED once the operator has pressed it a set number of times (three by default) inside a fixed time window. The window opens on the first accepted press. If it closes before enough presses have arrived, the partial count is thrown away and the block waits for a fresh first press. Once lit, the LED stays on until the synchronous reset.

The raw button line is asynchronous and its contacts bounce. Every piece of logic runs on the single system clock, and the button is only used as data. The signal first passes through a flip-flop synchronizer. A hold-time filter then accepts a new level only after the input has stayed steady long enough. A rising-edge detector turns each accepted press into a one-cycle pulse. A controller holds the window timer and the press counter.

The controller has three states:
- `ST_IDLE`: the timer is parked at zero.
- `ST_ARMED`: the window is open and the timer counts up.
- `ST_LIT`: the LED is on.

Its transitions are:
- ARM: `ST_IDLE` to `ST_ARMED` on the first press.
- COUNT: `ST_ARMED` stays in `ST_ARMED` on a press that is not the last one.
- EXPIRE: `ST_ARMED` to `ST_IDLE` when the timer reaches the window length.
- FIRE: `ST_ARMED` to `ST_LIT` on the final press. When the target is one press, FIRE goes from `ST_IDLE` to `ST_LIT`.
- HOLD: `ST_LIT` stays in `ST_LIT`.

The clock rate, window length, filter hold time, press target and synchronizer depth are all compile-time parameters. A simulation can therefore use a short window.

Top module: `press_window_detector`

## Requirements
- R1: `btn_raw` reaches the filter only through `SYNC_STAGES` (default 2) flip-flops. A clean press that completes the target lights `led` exactly `SYNC_STAGES + DB_CYCLES + 1` rising clock edges after `btn_raw` rises, and not one edge earlier.
- R2: The filter changes its accepted level only after the synchronized input has differed from that level for `DB_CYCLES = max(1, (CLK_HZ/1000)*DEBOUNCE_US/1000)` consecutive cycles. Any shorter pulse is not counted as a press.
- R3: A press counts once, on the low-to-high change of the accepted level, no matter how long it is held.
- R4: In `ST_IDLE` the window timer stays at zero. The window starts only on the first counted press, so a press that arrives after an expiry begins a new count of one.
- R5: With `WINDOW_CYCLES = max(1, (CLK_HZ/1000)*WINDOW_MS)` (250,000,000 at the defaults, which needs a 28-bit timer), `led` rises when the `PRESS_TARGET`-th press is counted fewer than `WINDOW_CYCLES` cycles after the first press.
- R6: When the timer reaches `WINDOW_CYCLES` in `ST_ARMED`, the count and the timer clear and the block returns to `ST_IDLE`. A press counted in that same cycle is discarded as late.
- R7: Once `led` is 1, it stays 1 until reset, and further presses have no effect on it.
- R8: While `rst` is 1 at a clock edge, `led` is 0, the controller is in `ST_IDLE`, and the filter level and all counts are cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| btn_raw | input | 1 | Asynchronous, bouncing push-button level (1 = pressed) |
| led | output | 1 | Lit once the target press count arrives inside the window |

## Verification
The embedded assertions check, on every cycle:
- the timer is parked at zero outside the open window and never passes the window length;
- the armed state holds fewer presses than the target;
- the edge detector never emits two pulses in a row;
- the filter only moves after a full hold run;
- the LED stays lit once set.

Some behaviours can only be shown by the bench's scenarios:
- a three-cycle glitch never counts;
- a long press counts once;
- a window expiry really discards the partial count;
- the third press lands exactly one cycle inside the window versus exactly on its edge;
- the end-to-end latency from button to LED is exact.

The bench's reference model tracks all of these cycle by cycle.

// File: rtl/pwd_pkg.sv
package pwd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_LIT   = 2'd2
    } win_state_t;

    function automatic int cycles_per_ms(input int hz);
        return hz / 1000;
    endfunction

    function automatic int at_least_one(input int v);
        return (v < 1) ? 1 : v;
    endfunction

endpackage

// File: rtl/pwd_sync.sv
module pwd_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    localparam int DEPTH = (STAGES < 2) ? 2 : STAGES;

    logic [DEPTH-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[DEPTH-2:0], d};
        end
    end

    assign q = chain_q[DEPTH-1];

endmodule

// File: rtl/pwd_debounce.sv
module pwd_debounce #(
    parameter int HOLD = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic level
);
    localparam int CNT_W = (HOLD < 2) ? 1 : $clog2(HOLD + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD - 1);

    logic [CNT_W-1:0] run_q;
    logic             level_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q   <= '0;
            level_q <= 1'b0;
        end else if (din == level_q) begin
            run_q <= '0;
        end else if (run_q == LAST) begin
            level_q <= din;
            run_q   <= '0;
        end else begin
            run_q <= run_q + CNT_W'(1);
        end
    end

    assign level = level_q;

    // R2: the accepted level only moves at the end of a full hold run
    a_r2_level_after_hold: assert property (@(posedge clk) disable iff (rst)
        (level_q != $past(level_q)) |-> ($past(run_q) == LAST));

endmodule

// File: rtl/pwd_edge.sv
module pwd_edge (
    input  logic clk,
    input  logic rst,
    input  logic level,
    output logic rise
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
        end else begin
            prev_q <= level;
        end
    end

    assign rise = level & ~prev_q;

    // R3: a held level yields a single pulse
    a_r3_single_pulse: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise);

endmodule

// File: rtl/pwd_window_fsm.sv
module pwd_window_fsm
    import pwd_pkg::*;
#(
    parameter int WINDOW_CYCLES = 250_000_000,
    parameter int TARGET        = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic press,
    output logic led
);
    localparam int WIN_W = $clog2(WINDOW_CYCLES + 1);
    localparam int CNT_W = (TARGET < 2) ? 1 : $clog2(TARGET + 1);
    localparam logic [WIN_W-1:0] WIN_LIMIT = WIN_W'(WINDOW_CYCLES);
    localparam logic [CNT_W-1:0] CNT_LAST  = CNT_W'(TARGET - 1);

    win_state_t       state_q, state_d;
    logic [WIN_W-1:0] timer_q;
    logic [CNT_W-1:0] count_q;
    logic             led_q;
    logic             at_limit;
    logic             last_press;

    assign at_limit   = (timer_q == WIN_LIMIT);
    assign last_press = (count_q == CNT_LAST);

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: ARM, COUNT, EXPIRE, FIRE, HOLD
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (press) begin
                    state_d = (TARGET <= 1) ? ST_LIT : ST_ARMED;
                end
            end
            ST_ARMED: begin
                if (at_limit) begin
                    state_d = ST_IDLE;
                end else if (press && last_press) begin
                    state_d = ST_LIT;
                end
            end
            ST_LIT: begin
                state_d = ST_LIT;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // window timer and press counter
    always_ff @(posedge clk) begin
        if (rst) begin
            timer_q <= '0;
            count_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    timer_q <= press ? WIN_W'(1) : '0;
                    count_q <= press ? CNT_W'(1) : '0;
                end
                ST_ARMED: begin
                    if (at_limit) begin
                        timer_q <= '0;
                        count_q <= '0;
                    end else begin
                        timer_q <= timer_q + WIN_W'(1);
                        if (press) begin
                            count_q <= count_q + CNT_W'(1);
                        end
                    end
                end
                ST_LIT: begin
                    timer_q <= '0;
                end
                default: begin
                    timer_q <= '0;
                    count_q <= '0;
                end
            endcase
        end
    end

    // output register
    always_ff @(posedge clk) begin
        if (rst) begin
            led_q <= 1'b0;
        end else begin
            led_q <= (state_d == ST_LIT);
        end
    end

    assign led = led_q;

    // R4: timer parked while idle
    a_r4_idle_timer_zero: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE) |-> (timer_q == '0));

    // R6: timer never passes the window, and reaching it closes the window
    a_r6_timer_bounded: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_ARMED) |-> (timer_q <= WIN_LIMIT));

    a_r6_expire_to_idle: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_ARMED && at_limit) |=> (state_q == ST_IDLE && led_q == 1'b0));

    // R5: the armed state never holds a full count
    a_r5_count_below_target: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_ARMED) |-> (count_q < CNT_W'(TARGET)));

    // R7: the LED is sticky
    a_r7_led_sticky: assert property (@(posedge clk) disable iff (rst)
        led_q |=> led_q);

endmodule

// File: rtl/press_window_detector.sv
module press_window_detector
    import pwd_pkg::*;
#(
    parameter int CLK_HZ       = 50_000_000,
    parameter int WINDOW_MS    = 5000,
    parameter int DEBOUNCE_US  = 10_000,
    parameter int PRESS_TARGET = 3,
    parameter int SYNC_STAGES  = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic btn_raw,
    output logic led
);
    localparam int WINDOW_CYCLES = at_least_one(cycles_per_ms(CLK_HZ) * WINDOW_MS);
    localparam int DB_CYCLES     = at_least_one(cycles_per_ms(CLK_HZ) * DEBOUNCE_US / 1000);

    logic btn_sync;
    logic btn_level;
    logic btn_rise;

    pwd_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (btn_raw),
        .q   (btn_sync)
    );

    pwd_debounce #(
        .HOLD (DB_CYCLES)
    ) u_debounce (
        .clk   (clk),
        .rst   (rst),
        .din   (btn_sync),
        .level (btn_level)
    );

    pwd_edge u_edge (
        .clk   (clk),
        .rst   (rst),
        .level (btn_level),
        .rise  (btn_rise)
    );

    pwd_window_fsm #(
        .WINDOW_CYCLES (WINDOW_CYCLES),
        .TARGET        (PRESS_TARGET)
    ) u_fsm (
        .clk   (clk),
        .rst   (rst),
        .press (btn_rise),
        .led   (led)
    );

    // R8: one cycle after a reset edge the LED is dark
    a_r8_reset_dark: assert property (@(posedge clk)
        $past(rst) |-> (led == 1'b0));

endmodule

// File: tb/press_window_detector_bench.sv
module press_window_detector_bench;

    localparam int CLK_HZ      = 100_000;
    localparam int WINDOW_MS   = 2;
    localparam int DEBOUNCE_US = 40;
    localparam int TARGET      = 3;
    localparam int STAGES      = 2;
    localparam int W   = (CLK_HZ / 1000) * WINDOW_MS;              // 200
    localparam int DB  = (CLK_HZ / 1000) * DEBOUNCE_US / 1000;     // 4
    localparam int LAT = STAGES + DB + 1;                          // 7

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic btn = 1'b0;
    logic led;

    int vectors = 0;
    int miscompares = 0;

    always #5 clk = ~clk;

    press_window_detector #(
        .CLK_HZ       (CLK_HZ),
        .WINDOW_MS    (WINDOW_MS),
        .DEBOUNCE_US  (DEBOUNCE_US),
        .PRESS_TARGET (TARGET),
        .SYNC_STAGES  (STAGES)
    ) u_press_window_detector (
        .clk     (clk),
        .rst     (rst),
        .btn_raw (btn),
        .led     (led)
    );

    // behavioural reference model
    int syncq[$];
    int m_lvl, m_lvl_old, m_run, m_mode, m_elapsed, m_count, s_in;
    bit m_pressed;
    bit m_led;

    always @(posedge clk) begin
        if (rst) begin
            syncq = {};
            for (int i = 0; i < STAGES; i++) syncq.push_back(0);
            m_lvl = 0; m_lvl_old = 0; m_run = 0;
            m_mode = 0; m_elapsed = 0; m_count = 0;
            m_led = 1'b0;
        end else begin
            s_in = syncq.pop_front();
            syncq.push_back(int'(btn));
            m_pressed = (m_lvl == 1) && (m_lvl_old == 0);
            m_lvl_old = m_lvl;
            if (s_in != m_lvl) begin
                if (m_run + 1 >= DB) begin
                    m_lvl = s_in;
                    m_run = 0;
                end else begin
                    m_run = m_run + 1;
                end
            end else begin
                m_run = 0;
            end
            if (m_mode == 0) begin
                if (m_pressed) begin
                    if (TARGET <= 1) m_mode = 2;
                    else begin
                        m_mode = 1; m_count = 1; m_elapsed = 1;
                    end
                end
            end else if (m_mode == 1) begin
                if (m_elapsed == W) begin
                    m_mode = 0; m_count = 0; m_elapsed = 0;
                end else begin
                    if (m_pressed) begin
                        m_count = m_count + 1;
                        if (m_count == TARGET) m_mode = 2;
                    end
                    m_elapsed = m_elapsed + 1;
                end
            end
            m_led = (m_mode == 2);
        end
    end

    // per-cycle comparison against the model (R5, R6 and the pipeline of R1..R3)
    always @(negedge clk) begin
        if (!rst) begin
            vectors++;
            if (led !== m_led) begin
                miscompares++;
                $display("FAIL R5/R6 model compare: led=%b expected %b at %0t", led, m_led, $time);
            end
        end
    end

    task automatic check(input string tag, input logic exp);
        vectors++;
        if (led !== exp) begin
            miscompares++;
            $display("FAIL %s: led=%b expected %b", tag, led, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic press(input int hold, input int gap);
        btn = 1'b1;
        tick(hold);
        btn = 1'b0;
        tick(gap);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        btn = 1'b0;
        tick(4);
        rst = 1'b0;
        tick(1);
    endtask

    // three clean presses; the third rises sp cycles after the first
    task automatic spaced_three(input int sp);
        btn = 1'b1; tick(10);
        btn = 1'b0; tick(40);
        btn = 1'b1; tick(10);
        btn = 1'b0; tick(sp - 60);
        btn = 1'b1; tick(10);
        btn = 1'b0; tick(20);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    endtask

    initial begin
        repeat (200_000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: run did not finish, expected completion");
        summary();
        $finish;
    end

    initial begin
        tick(3);
        check("R8 led dark during reset", 1'b0);
        rst = 1'b0;
        tick(2);
        check("R8 led dark after reset", 1'b0);

        // basic three presses, third one timed for latency
        press(10, 20);
        press(10, 20);
        check("R5 two presses not enough", 1'b0);
        btn = 1'b1;
        tick(LAT - 1);
        check("R1 latency one edge early", 1'b0);
        tick(1);
        check("R1 latency exact edge", 1'b1);
        tick(10);
        btn = 1'b0;
        tick(20);
        check("R5 three presses in window", 1'b1);
        press(10, 20);
        press(10, 20);
        tick(W + 20);
        check("R7 led held after more presses and time", 1'b1);
        do_reset();
        check("R8 reset clears led", 1'b0);

        // glitches shorter than the hold time
        for (int k = 0; k < 3; k++) press(3, 3);
        tick(10);
        press(10, 20);
        press(10, 20);
        check("R2 short glitches not counted", 1'b0);
        tick(W + 20);
        press(60, 20);
        press(10, 20);
        check("R3 long press counted once", 1'b0);
        press(10, 20);
        check("R3 third press after long hold", 1'b1);

        // expiry discards the partial count
        do_reset();
        press(10, 20);
        press(10, 20);
        tick(W + 20);
        check("R6 expired window dark", 1'b0);
        press(10, 20);
        press(10, 20);
        check("R6 partial count discarded", 1'b0);
        press(10, 20);
        check("R4 new window after expiry", 1'b1);

        // boundary: last cycle inside the window vs. exactly at its end
        do_reset();
        spaced_three(W - 1);
        check("R5 third press one cycle inside window", 1'b1);
        do_reset();
        spaced_three(W);
        check("R6 third press at window end is late", 1'b0);
        press(10, 20);
        press(10, 20);
        check("R6 late press not carried over", 1'b0);
        press(10, 20);
        check("R4 window restarts on next press", 1'b1);

        tick(5);
        summary();
        $finish;
    end

endmodule